// File: doc/BRIEF.md
# Thermostat Alert with Consecutive-Fault Filter

This block decides the level of a thermostat alert pin from a stream of finished temperature conversions. Each time the converter signals that a result is ready, the block compares the 13-bit two's-complement reading with a high limit and a low limit. It counts how many results in a row meet the condition it is currently watching. When that run reaches a programmed length, the block changes its alert state according to the selected thermostat policy.

Three policies are available. The comparator policy follows the temperature with hysteresis. The interrupt policy latches an event until software reads a register, and it alternates between arming on the high limit and arming on the low limit. The comparator-with-acknowledge policy sets like the comparator but releases only after the cool-down condition has been met and a later bus transaction has occurred. A polarity input selects whether the pin is active low or active high. The serial interface and the converter sit outside the block and supply the strobes.

Top module: `thermo_alert`

## Requirements
- R1: The run length needed to act is set by `fault_sel`: 0 needs 1 result, 1 needs 2, 2 needs 4 and 3 needs 6 consecutive qualifying results.
- R2: With `mode` 0 (comparator), the alert sets after the run length of results with temp >= `lim_hi`. It clears after the same run length of results with temp < `lim_lo`. Results between the limits leave the state unchanged.
- R3: With `mode` 0 or 3 (3 behaves as 0), `reg_rd`, `comm` and `shutdown` have no effect on the alert.
- R4: With `mode` 1 (interrupt), the alert sets after the run length of qualifying results and then holds through all later results. A `reg_rd` pulse or a `shutdown` pulse clears it.
- R5: In interrupt mode, arming starts on the high limit (temp >= `lim_hi`). Each clear swaps the arming, so the next set comes from temp < `lim_lo`, and the clear after that returns arming to the high limit.
- R6: With `mode` 2 (comparator with acknowledge), the alert sets as in R2. It clears only on a `comm` pulse that arrives in a cycle after the one in which the low-limit run length was reached. A `comm` pulse before that point, or in that same cycle, is ignored. Until the release, new results do not change the state.
- R7: `pol`=0 drives `alert_pin` low when the alert is active. `pol`=1 drives it high when active. `alert_pin` is registered, so it follows the alert state one clock later. Reset leaves the alert inactive with the pin at 1.
- R8: Comparisons use all 13 bits as signed two's complement, so negative limits work and a one-LSB difference decides the outcome.
- R9: Only cycles with `conv_done` high are evaluated. A result that fails the watched condition restarts the run count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new result is on `temp` |
| temp | input | 13 | Signed result, 1/16 degree per LSB |
| lim_hi | input | 13 | Signed high limit |
| lim_lo | input | 13 | Signed low limit |
| mode | input | 2 | Policy: 0 comparator, 1 interrupt, 2 comparator with acknowledge, 3 as 0 |
| fault_sel | input | 2 | Run-length select (R1) |
| pol | input | 1 | Pin polarity: 0 active low, 1 active high |
| reg_rd | input | 1 | One-cycle pulse: a register was read |
| comm | input | 1 | One-cycle pulse: a bus transaction took place |
| shutdown | input | 1 | One-cycle pulse: shutdown was entered |
| alert_pin | output | 1 | Registered alert level |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Run-length restart.** The bench breaks a run one result short and also holds a hot temperature on cycles without a strobe. A counter that fails to restart, or that counts idle cycles, would trip early.
- **Interrupt alternation.** The bench walks the arming through two complete clears, one by read and one by shutdown. A design that forgot to swap arming would set again on the wrong limit.
- **Acknowledge timing.** The bench issues `comm` before the cool-down, in the same cycle as the cool-down and after it. Only the last one may release the alert.
- **Signed limits.** The bench uses negative limits and one-LSB steps. Unsigned or truncated compares would flip the outcome at these points.

// File: rtl/thermo_alert_pkg.sv
`timescale 1ns/1ps
package thermo_alert_pkg;

  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    TM_CMP  = 2'b00,
    TM_INT  = 2'b01,
    TM_ICMP = 2'b10,
    TM_RSV  = 2'b11
  } tmode_e;

  function automatic logic [CNT_W-1:0] need_count(input logic [1:0] sel);
    logic [CNT_W-1:0] n;
    case (sel)
      2'd0:    n = CNT_W'(1);
      2'd1:    n = CNT_W'(2);
      2'd2:    n = CNT_W'(4);
      default: n = CNT_W'(6);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/fault_qualifier.sv
`timescale 1ns/1ps
module fault_qualifier
  import thermo_alert_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic              watch_cold,
  input  logic              hold,
  input  logic [CNT_W-1:0]  need,
  output logic              trip
);

  logic             hot, cold, cond;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  // full-width signed comparisons (R8)
  always_comb begin
    hot     = $signed(temp) >= $signed(lim_hi);
    cold    = $signed(temp) <  $signed(lim_lo);
    cond    = watch_cold ? cold : hot;
    cnt_nxt = cnt + CNT_W'(1);
    trip    = conv_done && !hold && cond && (cnt_nxt >= need);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (hold) begin
      cnt <= '0;
    end else if (conv_done) begin
      if (!cond || trip) cnt <= '0;
      else               cnt <= cnt_nxt;
    end
  end

  // R9: a failing result restarts the run
  p_miss_restarts_r9: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !hold && !cond) |=> (cnt == '0));

  // R9: no counting while the policy holds the state
  p_hold_clears_r9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (cnt == '0));

  // R9: non-strobe cycles leave the count alone
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !hold) |=> $stable(cnt));

endmodule

// File: rtl/alert_policy.sv
`timescale 1ns/1ps
module alert_policy
  import thermo_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       trip,
  input  logic       reg_rd,
  input  logic       comm,
  input  logic       shutdown,
  output logic       active,
  output logic       watch_cold,
  output logic       hold
);

  tmode_e md;
  logic   is_int, is_icmp;
  logic   arm_low, pend;

  always_comb begin
    md         = tmode_e'(mode);
    is_int     = (md == TM_INT);
    is_icmp    = (md == TM_ICMP);
    watch_cold = is_int ? arm_low : active;
    hold       = (is_int && active) || (is_icmp && pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      arm_low <= 1'b0;
      pend    <= 1'b0;
    end else if (is_int) begin
      if (active && (reg_rd || shutdown)) begin
        active  <= 1'b0;
        arm_low <= ~arm_low;
      end else if (trip) begin
        active <= 1'b1;
      end
    end else if (is_icmp) begin
      if (pend && comm) begin
        active <= 1'b0;
        pend   <= 1'b0;
      end else if (trip) begin
        if (active) pend   <= 1'b1;
        else        active <= 1'b1;
      end
    end else if (trip) begin
      active <= ~active;
    end
  end

  // R4: read clears a latched interrupt
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (is_int && active && reg_rd) |=> !active);

  // R5: a clear swaps the arming limit
  p_clear_swaps_arm_r5: assert property (@(posedge clk) disable iff (rst)
    (is_int && active && (reg_rd || shutdown)) |=> (arm_low != $past(arm_low)));

  // R6: only an acknowledge releases the alert
  p_needs_comm_r6: assert property (@(posedge clk) disable iff (rst)
    (is_icmp && active && !comm) |=> active);

  // R3: bus events do not move a comparator alert
  p_cmp_ignores_bus_r3: assert property (@(posedge clk) disable iff (rst)
    (!is_int && !is_icmp && !trip) |=> $stable(active));

endmodule

// File: rtl/alert_driver.sv
`timescale 1ns/1ps
module alert_driver (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic pol,
  output logic alert_pin
);

  always_ff @(posedge clk) begin
    if (rst) alert_pin <= 1'b1;
    else     alert_pin <= pol ? active : ~active;
  end

  // R7: the pin idles high after reset with active-low polarity
  p_idle_after_reset_r7: assert property (@(posedge clk)
    $fell(rst) |-> alert_pin);

endmodule

// File: rtl/thermo_alert.sv
`timescale 1ns/1ps
module thermo_alert
  import thermo_alert_pkg::*;
#(
  parameter int TEMP_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [TEMP_W-1:0] temp,
  input  logic [TEMP_W-1:0] lim_hi,
  input  logic [TEMP_W-1:0] lim_lo,
  input  logic [1:0]        mode,
  input  logic [1:0]        fault_sel,
  input  logic              pol,
  input  logic              reg_rd,
  input  logic              comm,
  input  logic              shutdown,
  output logic              alert_pin
);

  logic             trip, active, watch_cold, hold;
  logic [CNT_W-1:0] need;

  always_comb need = need_count(fault_sel);

  fault_qualifier #(.TEMP_W(TEMP_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .temp       (temp),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .watch_cold (watch_cold),
    .hold       (hold),
    .need       (need),
    .trip       (trip)
  );

  alert_policy u_policy (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .trip       (trip),
    .reg_rd     (reg_rd),
    .comm       (comm),
    .shutdown   (shutdown),
    .active     (active),
    .watch_cold (watch_cold),
    .hold       (hold)
  );

  alert_driver u_drv (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .pol       (pol),
    .alert_pin (alert_pin)
  );

  // R2: a trip always moves the alert in comparator mode
  p_trip_moves_r2: assert property (@(posedge clk) disable iff (rst)
    (trip && (mode == 2'b00)) |=> (active != $past(active)));

endmodule

// File: tb/test_thermo_alert.sv
`timescale 1ns/1ps
module test_thermo_alert;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_done = 1'b0;
  logic [12:0] temp = '0, lim_hi = 13'd1280, lim_lo = 13'd1200;
  logic [1:0]  mode = 2'd0, fault_sel = 2'd0;
  logic        pol = 1'b0, reg_rd = 1'b0, comm = 1'b0, shutdown = 1'b0;
  logic        alert_pin;

  int checks = 0, errors = 0;
  string cur_req = "R7";
  bit done = 1'b0;

  always #5 clk = ~clk;

  thermo_alert i_thermo_alert (
    .clk(clk), .rst(rst), .conv_done(conv_done), .temp(temp),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .mode(mode), .fault_sel(fault_sel),
    .pol(pol), .reg_rd(reg_rd), .comm(comm), .shutdown(shutdown),
    .alert_pin(alert_pin)
  );

  // behavioural reference
  bit m_pin = 1'b1, m_on = 1'b0, m_low = 1'b0, m_pend = 1'b0;
  int m_run = 0;

  always @(posedge clk) begin
    int md, need, t, hi, lo;
    bit busy, look_low, ok;
    if (rst) begin
      m_pin = 1'b1; m_on = 1'b0; m_low = 1'b0; m_pend = 1'b0; m_run = 0;
    end else begin
      m_pin = pol ? m_on : !m_on;
      md = (mode == 2'd3) ? 0 : int'(mode);
      case (fault_sel) 2'd0: need = 1; 2'd1: need = 2; 2'd2: need = 4; default: need = 6; endcase
      if (md == 1 && m_on && (reg_rd || shutdown)) begin
        m_on = 1'b0; m_low = !m_low; m_run = 0;
      end else if (md == 2 && m_pend && comm) begin
        m_on = 1'b0; m_pend = 1'b0; m_run = 0;
      end else begin
        busy = (md == 1 && m_on) || (md == 2 && m_pend);
        if (busy) m_run = 0;
        else if (conv_done) begin
          t = $signed(temp); hi = $signed(lim_hi); lo = $signed(lim_lo);
          look_low = (md == 1) ? m_low : m_on;
          ok = look_low ? (t < lo) : (t >= hi);
          if (!ok) m_run = 0;
          else begin
            m_run++;
            if (m_run >= need) begin
              m_run = 0;
              if (md == 1) m_on = 1'b1;
              else if (md == 2) begin
                if (m_on) m_pend = 1'b1; else m_on = 1'b1;
              end else m_on = !m_on;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (alert_pin !== m_pin) begin
        errors++;
        $display("FAIL %s model: alert_pin=%b expected=%b at %0t", cur_req, alert_pin, m_pin, $time);
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1; conv_done = 1'b0; reg_rd = 1'b0; comm = 1'b0; shutdown = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic conv(input int v, input bit with_comm = 1'b0);
    @(posedge clk); #1;
    temp = 13'(v); conv_done = 1'b1; comm = with_comm;
    @(posedge clk); #1;
    conv_done = 1'b0; comm = 1'b0;
  endtask

  task automatic pulse_rd();
    @(posedge clk); #1 reg_rd = 1'b1;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic pulse_comm();
    @(posedge clk); #1 comm = 1'b1;
    @(posedge clk); #1 comm = 1'b0;
  endtask

  task automatic pulse_sd();
    @(posedge clk); #1 shutdown = 1'b1;
    @(posedge clk); #1 shutdown = 1'b0;
  endtask

  task automatic expect_alert(input bit act, input string req);
    bit exp_pin;
    repeat (2) @(negedge clk);
    exp_pin = pol ? act : !act;
    checks++;
    if (alert_pin !== exp_pin) begin
      errors++;
      $display("FAIL %s: alert_pin=%b expected=%b at %0t", req, alert_pin, exp_pin, $time);
    end
  endtask

  localparam int HOT = 1300, MID = 1250, COLD = 1100;

  initial begin
    do_reset();
    cur_req = "R7"; expect_alert(1'b0, "R7 reset idle");

    // R2 comparator hysteresis
    cur_req = "R2";
    conv(HOT);  expect_alert(1'b1, "R2 set at high");
    conv(MID);  expect_alert(1'b1, "R2 between limits");
    conv(1199); expect_alert(1'b0, "R2 clear below low");

    // R9 / R1 run length 4
    cur_req = "R9"; fault_sel = 2'd2;
    for (int i = 0; i < 3; i++) conv(HOT);
    conv(1000);
    for (int i = 0; i < 3; i++) conv(HOT);
    expect_alert(1'b0, "R9 restart after miss");
    @(posedge clk); #1 temp = 13'(HOT);
    repeat (10) @(posedge clk);
    expect_alert(1'b0, "R9 idle cycles ignored");
    cur_req = "R1"; conv(HOT); expect_alert(1'b1, "R1 four in a row");
    cur_req = "R3";
    pulse_rd(); pulse_comm(); pulse_sd();
    expect_alert(1'b1, "R3 bus events ignored");
    cur_req = "R2";
    for (int i = 0; i < 3; i++) conv(COLD);
    expect_alert(1'b1, "R2 three cold of four");
    conv(COLD); expect_alert(1'b0, "R2 four cold clears");

    // R1 run length 6 and 2
    do_reset(); cur_req = "R1"; fault_sel = 2'd3;
    for (int i = 0; i < 5; i++) conv(HOT);
    expect_alert(1'b0, "R1 five of six");
    conv(HOT); expect_alert(1'b1, "R1 six in a row");
    do_reset(); fault_sel = 2'd1;
    conv(HOT); expect_alert(1'b0, "R1 one of two");
    conv(HOT); expect_alert(1'b1, "R1 two in a row");

    // R8 signed and LSB
    do_reset(); cur_req = "R8"; fault_sel = 2'd0;
    lim_hi = 13'(-80); lim_lo = 13'(-160);
    conv(-81);  expect_alert(1'b0, "R8 just under negative high");
    conv(-80);  expect_alert(1'b1, "R8 equal negative high");
    conv(-160); expect_alert(1'b1, "R8 equal negative low");
    conv(-161); expect_alert(1'b0, "R8 below negative low");
    lim_hi = 13'd1281; lim_lo = 13'd1200;
    conv(1280); expect_alert(1'b0, "R8 one LSB short");
    conv(1281); expect_alert(1'b1, "R8 one LSB reached");
    lim_hi = 13'd1280;

    // R4 / R5 interrupt
    do_reset(); mode = 2'd1; cur_req = "R4";
    conv(HOT);  expect_alert(1'b1, "R4 interrupt set");
    conv(HOT); conv(COLD);
    expect_alert(1'b1, "R4 held through results");
    pulse_rd(); expect_alert(1'b0, "R4 read clears");
    cur_req = "R5";
    conv(HOT); conv(HOT); expect_alert(1'b0, "R5 armed low ignores hot");
    conv(COLD); expect_alert(1'b1, "R5 set from low");
    cur_req = "R4"; pulse_sd(); expect_alert(1'b0, "R4 shutdown clears");
    cur_req = "R5";
    conv(COLD); expect_alert(1'b0, "R5 armed high ignores cold");
    conv(HOT);  expect_alert(1'b1, "R5 rearmed high");
    pulse_rd(); expect_alert(1'b0, "R4 read clears again");

    // R6 comparator with acknowledge
    do_reset(); mode = 2'd2; fault_sel = 2'd1; cur_req = "R6";
    pulse_comm();
    conv(HOT); conv(HOT); expect_alert(1'b1, "R6 set");
    pulse_comm(); expect_alert(1'b1, "R6 early comm ignored");
    conv(COLD); conv(COLD); expect_alert(1'b1, "R6 pending waits");
    conv(HOT); expect_alert(1'b1, "R6 results ignored while pending");
    pulse_comm(); expect_alert(1'b0, "R6 comm releases");
    conv(HOT); conv(HOT); conv(COLD);
    conv(COLD, 1'b1); expect_alert(1'b1, "R6 same-cycle comm ignored");
    pulse_comm(); expect_alert(1'b0, "R6 later comm releases");

    // R3 reserved mode
    do_reset(); mode = 2'd3; fault_sel = 2'd0; cur_req = "R3";
    conv(HOT); expect_alert(1'b1, "R3 mode 3 sets");
    pulse_rd(); pulse_sd(); expect_alert(1'b1, "R3 mode 3 ignores read");
    conv(COLD); expect_alert(1'b0, "R3 mode 3 clears like comparator");

    // R7 polarity
    do_reset(); mode = 2'd0; pol = 1'b1; cur_req = "R7";
    expect_alert(1'b0, "R7 active high idle");
    conv(HOT); expect_alert(1'b1, "R7 active high set");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: expected=finish actual=hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule